// File: doc/BRIEF.md
# Peripheral Reference Clock Enable Generator

This block turns tick streams from three clock sources into two single-cycle reference enable strobes for a pair of peripherals. All logic runs on one system clock. Every source is represented by a tick input, one cycle wide. Each source stage takes either the raw reference tick or its own multiplied tick. It can also be silenced. Multiplication happens outside the block: the multiplied ticks arrive as inputs.

A small register file sits behind a synchronous write port and a combinational read port. It holds three source control words and one peripheral control word. The peripheral word sets a shared source select, a shared 6-bit divisor and a separate enable for each output. Each output has its own counter. The counter advances on each tick of the selected source and emits one enable pulse every N ticks.

Top module: `periph_refclk_gen`

## Requirements
- R1: The register addresses are 0x100 (source A), 0x104 (source D) and 0x108 (source I) for the source words, and 0x154 for the peripheral word. A source word keeps bit 0 (stage reset), bit 1 (power-down), bit 3 (qualifier), bit 4 (force-bypass) and bits [18:12] (7-bit feedback value). The peripheral word keeps bit 0 (enable out0), bit 1 (enable out1), bits [5:4] (select) and bits [13:8] (divisor). All other bits read back as zero.
- R2: While `rst_n` is low, both outputs stay at 0. Reset clears all four words to zero, so both outputs come out of reset disabled.
- R3: With divisor N in 1..63, an enabled output pulses once per N ticks of the selected source. The first pulse follows the Nth tick after the counters restart, and each pulse appears one clock after its tick.
- R4: A divisor field of 0 behaves as divide-by-1: every selected tick produces a pulse.
- R5: An output whose enable bit is 0 produces no pulses, whatever the other fields hold.
- R6: Select codes 0 and 1 choose source I, code 2 chooses source A, and code 3 chooses source D.
- R7: When a source's force-bypass bit (bit 4) is 0 and its stage reset (bit 0) or power-down (bit 1) is 1, that source produces no ticks.
- R8: When force-bypass is 1, the source passes `ref_tick_i` unchanged, even when stage reset or power-down is also set.
- R9: When bits 0, 1 and 4 are all 0, the source passes its own multiplied tick from `pll_tick_i` and ignores `ref_tick_i`.
- R10: A write to the peripheral word restarts both counters from zero, and no pulse is emitted in the cycle after that write.
- R11: The two outputs share select and divisor but are enabled independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ref_tick_i | input | 1 | Raw reference tick, used by sources in force-bypass |
| pll_tick_i | input | 3 | Multiplied ticks: bit 0 source A, bit 1 source D, bit 2 source I |
| refclk_en_o | output | 2 | Reference enable pulses, bit 0 for out0, bit 1 for out1 |

## Verification
The assertions check four things on every cycle:
- a disabled output stays silent;
- each counter stays below its effective divisor;
- a gated source selected by the mux produces no pulse;
- a write to the peripheral word yields a quiet cycle.

Some behaviours are only visible in the directed scenarios:
- the exact pulse spacing for divisors 1, 5, 63 and 0;
- the mapping of the four select codes;
- the bypass precedence over stage reset and power-down;
- the masked readback of the control words;
- the silent outputs during and after a mid-run reset.

// File: rtl/prg_pkg.sv
package prg_pkg;
  parameter int ADDR_W  = 12;
  parameter int DATA_W  = 32;
  parameter int DIV_W   = 6;
  parameter int SEL_W   = 2;
  parameter int NUM_OUT = 2;
  parameter int NUM_SRC = 3;

  localparam int SRC_A = 0;
  localparam int SRC_D = 1;
  localparam int SRC_I = 2;

  localparam logic [ADDR_W-1:0] SRC_BASE_ADDR = 12'h100;
  localparam logic [ADDR_W-1:0] PERIPH_ADDR   = 12'h154;

  localparam int BIT_STG_RST = 0;
  localparam int BIT_PWR_DN  = 1;
  localparam int BIT_FORCE   = 4;
  localparam int SEL_LSB     = 4;
  localparam int DIV_LSB     = 8;

  localparam logic [DATA_W-1:0] SRC_MASK    = 32'h0007_F01B;
  localparam logic [DATA_W-1:0] PERIPH_MASK = 32'h0000_3F33;

  typedef struct packed {
    logic force_byp;
    logic stg_rst;
    logic pwr_dn;
  } src_ctl_t;

  typedef struct packed {
    logic [DIV_W-1:0]   divisor;
    logic [SEL_W-1:0]   sel;
    logic [NUM_OUT-1:0] enable;
  } per_ctl_t;
endpackage

// File: rtl/prg_regs.sv
module prg_regs
  import prg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output src_ctl_t          src_ctl [NUM_SRC],
  output per_ctl_t          per_ctl,
  output logic              restart
);
  logic [DATA_W-1:0] src_q [NUM_SRC];
  logic [DATA_W-1:0] src_d [NUM_SRC];
  logic [DATA_W-1:0] per_q;
  logic [DATA_W-1:0] per_d;
  logic              per_hit;

  assign per_hit = (addr == PERIPH_ADDR);
  assign restart = we && per_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [ADDR_W-1:0] MY_ADDR = SRC_BASE_ADDR + ADDR_W'(4 * g);
    logic hit;
    assign hit = we && (addr == MY_ADDR);

    always_comb begin
      src_d[g] = src_q[g];
      if (hit) src_d[g] = wdata & SRC_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[g] <= '0;
      else if (hit) src_q[g] <= src_d[g];
    end

    assign src_ctl[g].force_byp = src_q[g][BIT_FORCE];
    assign src_ctl[g].stg_rst   = src_q[g][BIT_STG_RST];
    assign src_ctl[g].pwr_dn    = src_q[g][BIT_PWR_DN];
  end

  always_comb begin
    per_d = per_q;
    if (restart) per_d = wdata & PERIPH_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= '0;
    else if (restart) per_q <= per_d;
  end

  assign per_ctl.divisor = per_q[DIV_LSB +: DIV_W];
  assign per_ctl.sel     = per_q[SEL_LSB +: SEL_W];
  assign per_ctl.enable  = per_q[0 +: NUM_OUT];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (addr == SRC_BASE_ADDR + ADDR_W'(4 * i)) rdata = src_q[i];
    end
    if (per_hit) rdata = per_q;
  end
endmodule

// File: rtl/prg_src_gate.sv
module prg_src_gate
  import prg_pkg::*;
(
  input  logic     ref_tick,
  input  logic     mult_tick,
  input  src_ctl_t ctl,
  output logic     tick_o
);
  always_comb begin
    if (ctl.force_byp)                tick_o = ref_tick;
    else if (ctl.stg_rst || ctl.pwr_dn) tick_o = 1'b0;
    else                              tick_o = mult_tick;
  end
endmodule

// File: rtl/prg_divider.sv
module prg_divider #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          enable_i,
  input  logic [DW-1:0] divisor_i,
  input  logic          restart_i,
  output logic          pulse_o
);
  logic [DW-1:0] cnt_q, cnt_d, last;
  logic          pulse_d, cnt_en;

  assign last   = (divisor_i == '0) ? '0 : divisor_i - 1'b1;
  assign cnt_en = restart_i || !enable_i || tick_i;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (restart_i || !enable_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q >= last) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else pulse_o <= pulse_d;
  end

  assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !pulse_o);

  assert_cnt_below_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

  assert_restart_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!pulse_o && cnt_q == '0));
endmodule

// File: rtl/periph_refclk_gen.sv
module periph_refclk_gen
  import prg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ref_tick_i,
  input  logic [NUM_SRC-1:0] pll_tick_i,
  output logic [NUM_OUT-1:0] refclk_en_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  src_ctl_t           src_ctl [NUM_SRC];
  per_ctl_t           per_ctl;
  logic               restart;
  logic [NUM_SRC-1:0] src_tick;
  logic               sel_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  prg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .src_ctl (src_ctl),
    .per_ctl (per_ctl),
    .restart (restart)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
    prg_src_gate u_gate (
      .ref_tick  (ref_tick_i),
      .mult_tick (pll_tick_i[s]),
      .ctl       (src_ctl[s]),
      .tick_o    (src_tick[s])
    );
  end

  always_comb begin
    case (per_ctl.sel)
      2'd2:    sel_tick = src_tick[SRC_A];
      2'd3:    sel_tick = src_tick[SRC_D];
      default: sel_tick = src_tick[SRC_I];
    endcase
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    prg_divider #(.DW(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .tick_i    (sel_tick),
      .enable_i  (per_ctl.enable[o]),
      .divisor_i (per_ctl.divisor),
      .restart_i (restart),
      .pulse_o   (refclk_en_o[o])
    );
  end

  assert_gated_src_silent_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!per_ctl.sel[1] && !src_ctl[SRC_I].force_byp &&
     (src_ctl[SRC_I].stg_rst || src_ctl[SRC_I].pwr_dn)) |=> (refclk_en_o == '0));

  assert_bypass_follows_ref_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (per_ctl.sel == 2'd3 && src_ctl[SRC_D].force_byp && !ref_tick_i) |=> (refclk_en_o == '0));

  assert_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_we && reg_addr == PERIPH_ADDR) |=> (refclk_en_o == '0));
endmodule

// File: tb/periph_refclk_gen_tb_top.sv
module periph_refclk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ref_tick_i;
  logic [2:0]  pll_tick_i;
  logic [1:0]  refclk_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  periph_refclk_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ref_tick_i  (ref_tick_i),
    .pll_tick_i  (pll_tick_i),
    .refclk_en_o (refclk_en_o)
  );

  localparam logic [11:0] A_SRCA = 12'h100;
  localparam logic [11:0] A_SRCD = 12'h104;
  localparam logic [11:0] A_SRCI = 12'h108;
  localparam logic [11:0] A_PER  = 12'h154;

  function automatic logic [31:0] per_word(int div, int sel, int en);
    return (32'(div) << 8) | (32'(sel) << 4) | 32'(en);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(logic [11:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
    @(negedge clk);
  endtask

  // Ticks every cycle for n cycles; each output compared against its period
  // (0 = never pulses). Pulse expected one clock after every per-th tick.
  task automatic run_seq(string req, int n, logic rt, logic [2:0] pt, int per0, int per1);
    int bad0 = 0, bad1 = 0, cnt0 = 0, cnt1 = 0;
    int e0 = 0, e1 = 0;
    for (int i = 0; i < n; i++) begin
      ref_tick_i = rt; pll_tick_i = pt;
      @(negedge clk);
      e0 += (per0 != 0 && (i + 1) % per0 == 0) ? 1 : 0;
      e1 += (per1 != 0 && (i + 1) % per1 == 0) ? 1 : 0;
      if (refclk_en_o[0] != (per0 != 0 && (i + 1) % per0 == 0)) bad0++;
      if (refclk_en_o[1] != (per1 != 0 && (i + 1) % per1 == 0)) bad1++;
      cnt0 += refclk_en_o[0]; cnt1 += refclk_en_o[1];
    end
    ref_tick_i = 1'b0; pll_tick_i = '0;
    check(bad0 == 0, {req, " out0 pulses"}, cnt0, e0);
    check(bad1 == 0, {req, " out1 pulses"}, cnt1, e1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    ref_tick_i = 1'b0; pll_tick_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check(refclk_en_o == 2'b00, "R2 outputs after reset", refclk_en_o, 0);
    rd_check(A_SRCA, 32'h0, "R2 src A word reset");
    rd_check(A_SRCD, 32'h0, "R2 src D word reset");
    rd_check(A_SRCI, 32'h0, "R2 src I word reset");
    rd_check(A_PER,  32'h0, "R2 periph word reset");
    run_seq("R2 disabled after reset", 6, 1'b1, 3'b111, 0, 0);
  endtask

  task automatic t_regs_R1();
    wr(A_SRCA, 32'hFFFF_FFFF);
    wr(A_SRCD, 32'h0000_0013);
    wr(A_SRCI, 32'hFFFF_FFFF);
    wr(A_PER,  32'hFFFF_FFFF);
    rd_check(A_SRCA, 32'h0007_F01B, "R1 src A mask");
    rd_check(A_SRCD, 32'h0000_0013, "R1 src D value");
    rd_check(A_SRCI, 32'h0007_F01B, "R1 src I mask");
    rd_check(A_PER,  32'h0000_3F33, "R1 periph mask");
    wr(A_SRCA, 0); wr(A_SRCD, 0); wr(A_SRCI, 0); wr(A_PER, 0);
    rd_check(A_SRCI, 32'h0, "R1 src I cleared");
  endtask

  task automatic t_divide_R3();
    wr(A_PER, per_word(5, 0, 3));
    run_seq("R3 div5", 15, 1'b0, 3'b100, 5, 5);
    wr(A_PER, per_word(1, 0, 3));
    run_seq("R3 div1", 4, 1'b0, 3'b100, 1, 1);
    wr(A_PER, per_word(63, 0, 3));
    run_seq("R3 div63", 126, 1'b0, 3'b100, 63, 63);
  endtask

  task automatic t_div0_R4();
    wr(A_PER, per_word(0, 0, 3));
    run_seq("R4 div0 as div1", 5, 1'b0, 3'b100, 1, 1);
  endtask

  task automatic t_enable_R5_R11();
    wr(A_PER, per_word(3, 0, 1));
    run_seq("R11 only out0 enabled", 9, 1'b0, 3'b100, 3, 0);
    wr(A_PER, per_word(2, 0, 2));
    run_seq("R11 only out1 enabled", 6, 1'b0, 3'b100, 0, 2);
    wr(A_PER, per_word(1, 3, 0));
    run_seq("R5 both disabled", 6, 1'b1, 3'b111, 0, 0);
  endtask

  task automatic t_select_R6();
    wr(A_PER, per_word(2, 1, 3));
    run_seq("R6 sel1 picks I", 4, 1'b0, 3'b100, 2, 2);
    wr(A_PER, per_word(2, 2, 3));
    run_seq("R6 sel2 ignores I", 4, 1'b0, 3'b100, 0, 0);
    run_seq("R6 sel2 picks A", 4, 1'b0, 3'b001, 2, 2);
    wr(A_PER, per_word(2, 3, 3));
    run_seq("R6 sel3 ignores A", 4, 1'b0, 3'b001, 0, 0);
    run_seq("R6 sel3 picks D", 4, 1'b0, 3'b010, 2, 2);
    wr(A_PER, per_word(2, 0, 3));
    run_seq("R6 sel0 ignores D", 4, 1'b0, 3'b010, 0, 0);
  endtask

  task automatic t_gate_R7();
    wr(A_SRCI, 32'h1);
    wr(A_PER, per_word(1, 0, 3));
    run_seq("R7 stage reset silences", 5, 1'b1, 3'b111, 0, 0);
    wr(A_SRCI, 32'h2);
    wr(A_PER, per_word(1, 0, 3));
    run_seq("R7 power-down silences", 5, 1'b1, 3'b111, 0, 0);
    wr(A_SRCI, 32'h0);
  endtask

  task automatic t_bypass_R8();
    wr(A_SRCD, 32'h13);
    wr(A_PER, per_word(2, 3, 3));
    run_seq("R8 bypass passes ref", 6, 1'b1, 3'b000, 2, 2);
    run_seq("R8 bypass ignores mult tick", 6, 1'b0, 3'b010, 0, 0);
    wr(A_SRCD, 32'h0);
  endtask

  task automatic t_normal_R9();
    wr(A_PER, per_word(1, 2, 3));
    run_seq("R9 normal ignores ref", 5, 1'b1, 3'b000, 0, 0);
    run_seq("R9 normal passes mult", 3, 1'b0, 3'b001, 1, 1);
  endtask

  task automatic t_restart_R10();
    wr(A_PER, per_word(4, 0, 3));
    run_seq("R10 partial count", 2, 1'b0, 3'b100, 4, 4);
    wr(A_PER, per_word(4, 0, 3));
    run_seq("R10 counts from zero after write", 8, 1'b0, 3'b100, 4, 4);
  endtask

  task automatic t_midreset_R2();
    int seen = 0;
    wr(A_PER, per_word(1, 0, 3));
    ref_tick_i = 1'b1; pll_tick_i = 3'b111;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(refclk_en_o == 2'b00, "R2 silent at reset assert", refclk_en_o, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      seen += (refclk_en_o != 0) ? 1 : 0;
    end
    check(seen == 0, "R2 silent during reset", seen, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      seen += (refclk_en_o != 0) ? 1 : 0;
    end
    ref_tick_i = 1'b0; pll_tick_i = '0;
    check(seen == 0, "R2 silent after reset release", seen, 0);
    rd_check(A_PER, 32'h0, "R2 periph word cleared by reset");
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_regs_R1();
    t_divide_R3();
    t_div0_R4();
    t_enable_R5_R11();
    t_select_R6();
    t_gate_R7();
    t_bypass_R8();
    t_normal_R9();
    t_restart_R10();
    t_midreset_R2();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule